// File: doc/BRIEF.md
# Memory Controller Error-Check Register File

This block is the register file that sits beside an error-correcting DRAM controller. It gives software a word-addressed view of the controller's settings and fault records. The settings are an enable word, a delay word, a video configuration word, a diagnostic word and two event counters. The fault records are a fault status word and two fault address words. The correction logic elsewhere in the controller reports each fault through a capture port. That port loads the fault records and may raise an interrupt. Software clears the interrupt by writing the fault status word.

A four-bit variant code is fixed by a parameter and differs between chip variants. It decides which enable bits can be written and which enable bits survive a reset. It also decides whether a small byte-wide diagnostic window exists, which only variant 0 has. The variant code is returned in the top nibble of the enable word.

The bus is synchronous, with one access per cycle. An access is a select, a write strobe, a 13-bit byte address and 32-bit write data. Read data appears registered in the cycle after the read.

Top module: `memctl_csr`

## Requirements
- R1: Address bit 12 at 0 selects the word window. There the register index is address bits 11:2, with 0 enable, 1 delay, 2 fault status, 3 video, 4 fault address A, 5 fault address B, 6 diagnostic, 7 event count 0 and 8 event count 1. A read loads the selected word onto `rdata` at the clock edge of the access, and `rdata` holds that value until the next read.
- R2: A write to the enable word with variant 0 stores data AND 0x00000103. With any other variant it stores {variant, 28'h0} OR (data AND 0x00000BFF). Bits 31:28 of the enable word always read as the variant code.
- R3: A write to the delay word stores data AND 0x7FFFFFFF.
- R4: Any write to the fault status word stores the full data word and drops `irq` in the following cycle, unless a capture in the same cycle raises it.
- R5: The two fault address words cannot be written from the bus. They change only on a capture or a reset.
- R6: A reset gives delay 0x00000020 and fault address A 0x07C00000. Fault status, video, fault address B, diagnostic, both event counters, `irq` and `rdata` become zero.
- R7: On reset the enable word keeps only bit 8 with variant 0. With other variants it keeps mask 0xFF000BFC. At power-up the enable word holds {variant, 28'h0}.
- R8: With variant 0 and address bit 12 at 1, address bits 1:0 pick one of four byte locations. A write stores data bits 7:0 there, and a read returns the byte in bits 7:0 with all higher bits zero. The bytes clear on reset. With any other variant, reads at that window return zero and writes do nothing.
- R9: In the word window, a read at an index of 9 or more returns zero and a write at such an index changes nothing.
- R10: Event count 1 is stored and read separately from event count 0.
- R11: A capture (`flt_valid`) loads the fault status word from `flt_status` and the two fault address words from `flt_addr_a` and `flt_addr_b`. It sets `irq` when status bit 3 (uncorrectable) is set. It also sets `irq` when status bit 0 (correctable) is set while enable bit 1 is 1. Otherwise `irq` is left as it was.
- R12: A capture that arrives while `irq` is high also sets bit 16 (multiple errors) of the stored fault status.
- R13: When a capture and a bus write to the fault status word fall in the same cycle, the capture value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Bus access in this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Byte address; bit 12 selects the byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Fault interrupt |
| flt_valid | input | 1 | Fault capture strobe |
| flt_status | input | 32 | Fault status to record |
| flt_addr_a | input | 32 | First fault address word |
| flt_addr_b | input | 32 | Second fault address word |

## Verification
The bench runs two instances side by side, variant 0 and variant 1, on the same bus. This separates the two enable masks, the two reset retention masks and the presence of the byte window. Directed cases write all-ones and all-zeros to every index, including the unmapped ones and the read-only fault addresses, so that any leaked bit shows up. Capture sequences first raise the interrupt with the correctable bit while interrupts are disabled and then enabled, then with the uncorrectable bit, and then a second capture with the interrupt pending. This separates the raise rules from the multiple-error marking. A random phase mixes writes, reads and captures at random indices, and both windows are compared against a bench model.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;
  localparam int NREG    = 9;
  localparam int IX_EN   = 0;
  localparam int IX_DLY  = 1;
  localparam int IX_FST  = 2;
  localparam int IX_VID  = 3;
  localparam int IX_FA   = 4;
  localparam int IX_FB   = 5;
  localparam int IX_DIAG = 6;
  localparam int IX_EC0  = 7;
  localparam int IX_EC1  = 8;

  localparam logic [31:0] DLY_RST = 32'h0000_0020;
  localparam logic [31:0] FA_RST  = 32'h07C0_0000;
  localparam int ST_CE   = 0;
  localparam int ST_UE   = 3;
  localparam int ST_MULT = 16;
  localparam int EN_IE   = 1;

  function automatic logic [31:0] en_write(input logic [3:0] v, input logic [31:0] d);
    if (v == 4'd0) return d & 32'h0000_0103;
    return {v, 28'h0} | (d & 32'h0000_0BFF);
  endfunction

  function automatic logic [31:0] en_keep(input logic [3:0] v, input logic [31:0] cur);
    if (v == 4'd0) return cur & 32'h0000_0100;
    return cur & 32'hFF00_0BFC;
  endfunction

  function automatic logic [31:0] dly_write(input logic [31:0] d);
    return d & 32'h7FFF_FFFF;
  endfunction

  function automatic logic fault_raise(input logic [31:0] st, input logic ie);
    return st[ST_UE] | (st[ST_CE] & ie);
  endfunction
endpackage

// File: rtl/memctl_csr_decode.sv
module memctl_csr_decode #(
  parameter int ADDR_W = 13,
  parameter int NREG   = 9,
  localparam int IDX_W = ADDR_W - 3
) (
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wr_hit,
  output logic              rd_main,
  output logic [IDX_W-1:0]  idx,
  output logic              idx_ok,
  output logic              diag_wr,
  output logic              diag_rd,
  output logic [1:0]        diag_sel
);
  logic window;
  assign window   = addr[ADDR_W-1];
  assign idx      = addr[ADDR_W-2:2];
  assign idx_ok   = idx < IDX_W'(NREG);
  assign rd_main  = sel & ~wr_en & ~window;
  assign diag_wr  = sel & wr_en & window;
  assign diag_rd  = sel & ~wr_en & window;
  assign diag_sel = addr[1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign wr_hit[g] = sel & wr_en & ~window & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/memctl_csr_diag.sv
module memctl_csr_diag #(
  parameter bit PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] sel,
  input  logic [7:0] wbyte,
  output logic [7:0] rbyte
);
  if (PRESENT) begin : g_on
    logic [7:0] mem [4];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < 4; i++) mem[i] <= '0;
      end else if (wr) begin
        mem[sel] <= wbyte;
      end
    end
    assign rbyte = mem[sel];
  end else begin : g_off
    logic unused_diag;
    assign unused_diag = ^{clk, rst_n, wr, sel, wbyte};
    assign rbyte = '0;
  end
endmodule

// File: rtl/memctl_csr_fault.sv
module memctl_csr_fault
  import memctl_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flt_valid,
  input  logic [31:0] flt_status,
  input  logic [31:0] flt_addr_a,
  input  logic [31:0] flt_addr_b,
  input  logic        st_wr,
  input  logic [31:0] wdata,
  input  logic        ie,
  output logic [31:0] status,
  output logic [31:0] fa_q,
  output logic [31:0] fb_q,
  output logic        irq
);
  logic raise;
  assign raise = flt_valid & fault_raise(flt_status, ie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      fa_q   <= FA_RST;
      fb_q   <= '0;
      irq    <= 1'b0;
    end else begin
      if (flt_valid) begin
        status <= flt_status | (irq ? (32'd1 << ST_MULT) : 32'd0);
        fa_q   <= flt_addr_a;
        fb_q   <= flt_addr_b;
      end else if (st_wr) begin
        status <= wdata;
      end
      if (raise)      irq <= 1'b1;
      else if (st_wr) irq <= 1'b0;
    end
  end

  a_r4_status_write_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !flt_valid) |=> !irq);
  a_r11_uncorrectable_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_status[ST_UE]) |=> irq);
  a_r12_pending_marks_multiple: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && irq) |=> status[ST_MULT]);
  a_r5_fault_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> ($stable(fa_q) && $stable(fb_q)));
endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
  import memctl_csr_pkg::*;
#(
  parameter logic [3:0] VARIANT = 4'd0,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  input  logic              flt_valid,
  input  logic [31:0]       flt_status,
  input  logic [31:0]       flt_addr_a,
  input  logic [31:0]       flt_addr_b
);
  localparam int IDX_W   = ADDR_W - 3;
  localparam bit DIAG_ON = (VARIANT == 4'd0);

  logic [NREG-1:0]  wr_hit;
  logic             rd_main, idx_ok, diag_wr, diag_rd;
  logic [IDX_W-1:0] idx;
  logic [1:0]       diag_sel;
  logic [7:0]       diag_byte;
  logic [31:0]      st_q, fa_q, fb_q, rd_word;
  logic [31:0]      en_q = {VARIANT, 28'h0};
  logic [31:0]      dly_q, vid_q, dg_q, ec0_q, ec1_q;

  memctl_csr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .sel(sel), .wr_en(wr_en), .addr(addr), .wr_hit(wr_hit), .rd_main(rd_main),
    .idx(idx), .idx_ok(idx_ok), .diag_wr(diag_wr), .diag_rd(diag_rd), .diag_sel(diag_sel)
  );

  memctl_csr_diag #(.PRESENT(DIAG_ON)) u_diag (
    .clk(clk), .rst_n(rst_n), .wr(diag_wr), .sel(diag_sel),
    .wbyte(wdata[7:0]), .rbyte(diag_byte)
  );

  memctl_csr_fault u_flt (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_status(flt_status),
    .flt_addr_a(flt_addr_a), .flt_addr_b(flt_addr_b), .st_wr(wr_hit[IX_FST]),
    .wdata(wdata), .ie(en_q[EN_IE]), .status(st_q), .fa_q(fa_q), .fb_q(fb_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= en_keep(VARIANT, en_q);
      dly_q <= DLY_RST;
      vid_q <= '0;
      dg_q  <= '0;
      ec0_q <= '0;
      ec1_q <= '0;
    end else begin
      if (wr_hit[IX_EN])   en_q  <= en_write(VARIANT, wdata);
      if (wr_hit[IX_DLY])  dly_q <= dly_write(wdata);
      if (wr_hit[IX_VID])  vid_q <= wdata;
      if (wr_hit[IX_DIAG]) dg_q  <= wdata;
      if (wr_hit[IX_EC0])  ec0_q <= wdata;
      if (wr_hit[IX_EC1])  ec1_q <= wdata;
    end
  end

  logic [31:0] view [NREG];
  assign view[IX_EN]   = en_q;
  assign view[IX_DLY]  = dly_q;
  assign view[IX_FST]  = st_q;
  assign view[IX_VID]  = vid_q;
  assign view[IX_FA]   = fa_q;
  assign view[IX_FB]   = fb_q;
  assign view[IX_DIAG] = dg_q;
  assign view[IX_EC0]  = ec0_q;
  assign view[IX_EC1]  = ec1_q;

  always_comb begin
    rd_word = '0;
    if (idx_ok) begin
      for (int i = 0; i < NREG; i++) begin
        if (idx == IDX_W'(i)) rd_word = view[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_main) rdata <= rd_word;
    else if (diag_rd) rdata <= {24'h0, diag_byte};
  end

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_main && !idx_ok) |=> (rdata == 32'h0));
  a_r2_variant_in_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_main && idx == '0) |=> (rdata[31:28] == VARIANT));
  a_r1_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr_en) |=> $stable(rdata));
endmodule

// File: tb/memctl_csr_test.sv
module memctl_csr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr_en = 1'b0, flt_valid = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0, flt_status = '0, flt_addr_a = '0, flt_addr_b = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;

  always #(CLK_PERIOD/2) clk = ~clk;

  memctl_csr #(.VARIANT(4'd0)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata0), .irq(irq0), .flt_valid(flt_valid), .flt_status(flt_status),
    .flt_addr_a(flt_addr_a), .flt_addr_b(flt_addr_b));
  memctl_csr #(.VARIANT(4'd1)) uut_v1 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata1), .irq(irq1), .flt_valid(flt_valid), .flt_status(flt_status),
    .flt_addr_a(flt_addr_a), .flt_addr_b(flt_addr_b));

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] mdl [2][9];
  logic [7:0]  mdg [4];
  logic        mirq [2];

  function automatic logic [3:0] vc(input int k);
    return (k == 0) ? 4'd0 : 4'd1;
  endfunction

  function automatic logic [31:0] en_exp(input int k, input logic [31:0] d);
    if (k == 0) return {23'h0, d[8], 6'h0, d[1:0]};
    return {vc(k), 16'h0, d[11], 1'b0, d[9:0]};
  endfunction

  function automatic logic [31:0] rd_exp(input int k, input logic [12:0] a);
    int ix;
    if (a[12]) return (k == 0) ? {24'h0, mdg[a[1:0]]} : 32'h0;
    ix = int'(a[11:2]);
    return (ix < 9) ? mdl[k][ix] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [12:0] a, input logic [31:0] d);
    int ix;
    for (int k = 0; k < 2; k++) begin
      if (a[12]) begin
        if (k == 0) mdg[a[1:0]] = d[7:0];
      end else begin
        ix = int'(a[11:2]);
        case (ix)
          0: mdl[k][0] = en_exp(k, d);
          1: mdl[k][1] = {1'b0, d[30:0]};
          2: begin mdl[k][2] = d; mirq[k] = 1'b0; end
          3, 6, 7, 8: mdl[k][ix] = d;
          default: ;
        endcase
      end
    end
  endtask

  task automatic model_capture(input logic [31:0] st, input logic [31:0] a0,
                               input logic [31:0] a1, input logic old0, input logic old1);
    for (int k = 0; k < 2; k++) begin
      logic old;
      old = (k == 0) ? old0 : old1;
      mdl[k][2] = old ? (st | 32'h0001_0000) : st;
      mdl[k][4] = a0;
      mdl[k][5] = a1;
      if (st[3] || (st[0] && mdl[k][0][1])) mirq[k] = 1'b1;
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      mdl[k][0] = (k == 0) ? (mdl[k][0] & 32'h100) : (mdl[k][0] & 32'hFF00_0BFC);
      mdl[k][1] = 32'h20;
      mdl[k][4] = 32'h07C0_0000;
      for (int i = 2; i < 9; i++) if (i != 4) mdl[k][i] = 32'h0;
      mirq[k] = 1'b0;
    end
    for (int i = 0; i < 4; i++) mdg[i] = 8'h0;
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    sel = 1; wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    sel = 0; wr_en = 0;
  endtask

  task automatic bus_read(input logic [12:0] a, input string req);
    sel = 1; wr_en = 0; addr = a;
    @(posedge clk);
    @(negedge clk);
    sel = 0;
    chk({req, " v0"}, rdata0, rd_exp(0, a));
    chk({req, " v1"}, rdata1, rd_exp(1, a));
  endtask

  task automatic capture(input logic [31:0] st, input logic [31:0] a0, input logic [31:0] a1,
                         input bit with_write, input logic [31:0] wd);
    logic o0, o1;
    o0 = mirq[0]; o1 = mirq[1];
    flt_valid = 1; flt_status = st; flt_addr_a = a0; flt_addr_b = a1;
    if (with_write) begin sel = 1; wr_en = 1; addr = 13'h008; wdata = wd; end
    @(posedge clk);
    if (with_write) model_write(13'h008, wd);
    model_capture(st, a0, a1, o0, o1);
    if (with_write) begin
      for (int k = 0; k < 2; k++)
        if (!(st[3] || (st[0] && mdl[k][0][1]))) mirq[k] = 1'b0;
    end
    @(negedge clk);
    flt_valid = 0; sel = 0; wr_en = 0;
  endtask

  task automatic chk_irq(input string req);
    chk({req, " irq v0"}, {31'h0, irq0}, {31'h0, mirq[0]});
    chk({req, " irq v1"}, {31'h0, irq1}, {31'h0, mirq[1]});
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24680));
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 9; i++) mdl[k][i] = 32'h0;
      mdl[k][0] = {vc(k), 28'h0};
      mirq[k] = 1'b0;
    end
    @(negedge clk);
    do_reset();
    chk("R6 rdata after reset", rdata0, 32'h0);
    for (int i = 0; i < 9; i++) bus_read(13'(i * 4), "R6 reset value");
    chk_irq("R6");

    bus_write(13'h000, 32'hFFFF_FFFF); bus_read(13'h000, "R2 enable mask ones");
    bus_write(13'h000, 32'h0000_0000); bus_read(13'h000, "R2 enable mask zeros");
    bus_write(13'h004, 32'hFFFF_FFFF); bus_read(13'h004, "R3 delay mask");
    bus_write(13'h010, 32'hDEAD_BEEF); bus_write(13'h014, 32'hCAFE_F00D);
    bus_read(13'h010, "R5 fault addr A");
    bus_read(13'h014, "R5 fault addr B");
    bus_write(13'h01C, 32'h1111_1111); bus_write(13'h020, 32'h2222_2222);
    bus_read(13'h01C, "R10 event count 0");
    bus_read(13'h020, "R10 event count 1");
    bus_write(13'h00C, 32'hA5A5_0F0F); bus_read(13'h00C, "R1 video");
    bus_write(13'h018, 32'h5A5A_F0F0); bus_read(13'h018, "R1 diagnostic word");
    bus_write(13'h024, 32'hFFFF_FFFF); bus_write(13'h03C, 32'h1234_5678);
    bus_read(13'h024, "R9 index 9 reads zero");
    bus_read(13'h03C, "R9 index 15 reads zero");
    for (int i = 0; i < 9; i++) bus_read(13'(i * 4), "R9 no side effect");
    for (int i = 0; i < 4; i++) bus_write(13'h1000 + 13'(i), 32'hFFFF_FF00 | 32'(8'h31 + i));
    for (int i = 0; i < 4; i++) bus_read(13'h1000 + 13'(i), "R8 byte window");

    bus_write(13'h000, 32'h0);
    capture(32'h0000_0001, 32'h1, 32'h2, 0, 0); chk_irq("R11 correctable ie off");
    bus_read(13'h008, "R11 status captured");
    bus_read(13'h010, "R11 addr A captured");
    bus_read(13'h014, "R11 addr B captured");
    bus_write(13'h000, 32'h0000_0002);
    capture(32'h0000_0001, 32'h3, 32'h4, 0, 0); chk_irq("R11 correctable ie on");
    capture(32'h0000_0001, 32'h5, 32'h6, 0, 0); chk_irq("R12 second capture");
    bus_read(13'h008, "R12 multiple error bit");
    bus_write(13'h008, 32'h0000_00F0); chk_irq("R4 status write clears");
    bus_read(13'h008, "R4 status stored");
    bus_write(13'h000, 32'h0);
    capture(32'h0000_0008, 32'h7, 32'h8, 0, 0); chk_irq("R11 uncorrectable");
    capture(32'h0000_0000, 32'h9, 32'hA, 1, 32'h0000_7777); chk_irq("R13 same cycle");
    bus_read(13'h008, "R13 capture wins");

    bus_write(13'h000, 32'hFFFF_FFFF);
    do_reset();
    bus_read(13'h000, "R7 enable retention");
    for (int i = 1; i < 9; i++) bus_read(13'(i * 4), "R6 second reset");
    bus_read(13'h1002, "R8 bytes cleared");

    for (int n = 0; n < 400; n++) begin
      int op;
      logic [12:0] a;
      op = int'($urandom % 4);
      a = {($urandom % 5 == 0) ? 1'b1 : 1'b0, 6'h0, 4'($urandom), 2'($urandom)};
      if (!a[12]) a[1:0] = 2'b00;
      case (op)
        0: bus_write(a, $urandom);
        1: bus_read(a, "R1 random read");
        2: begin
          capture($urandom & 32'h0000_FF09, $urandom, $urandom, 0, 0);
          chk_irq("R11 random capture");
        end
        default: begin
          bus_write(13'h008, $urandom);
          chk_irq("R4 random status write");
        end
      endcase
    end
    for (int i = 0; i < 9; i++) bus_read(13'(i * 4), "R1 final sweep");
    finish_run();
  end
endmodule